// File: doc/BRIEF.md
# Test Control Register File

This block is the register-side front end of a storage test harness. It sits on a simple single-port register bus in the user clock domain. It decodes each register address into one of six regions:

- a write-only parameter bank;
- a read-only status view;
- a write-only 16-dword command entry;
- a read-only completion view;
- a read-only window onto a 128-bit identify RAM;
- a read/write window onto a 128-bit command RAM.

The parameters it holds are a 48-bit start address, a 48-bit transfer length, a pattern select and a timeout. They drive the data generator and the storage engine outside the block. Writing the command register launches an operation with a one-cycle request.

Every read passes through two registered multiplexers. The first picks a word inside a region using the low address bits. The second picks the region using the high address bits. Read data and its valid strobe therefore appear exactly two clocks after the request, whatever the address. The two RAMs are outside the block. The block drives their address, write data and byte enables, and each RAM returns its read data one clock after the address.

Top module: `tcr_regfile`

## Requirements
- R1: After reset, all parameter outputs, the command entry, the command code and device fields, `cmd_req` and `reg_rd_valid` are zero.
- R2: `reg_rd_valid` is high exactly two clocks after each cycle in which `reg_rd_req` is high. It is high for one cycle per request, and back-to-back requests give back-to-back strobes. `reg_rd_data` is valid in the same cycle as `reg_rd_valid`.
- R3: Each write to the parameter region updates all 32 bits of the target register regardless of `reg_wr_be`. The mapping is:
  - byte offset 0x00: start address bits 31:0;
  - byte offset 0x04: start address bits 47:32, from data bits 15:0;
  - byte offset 0x08: length bits 31:0;
  - byte offset 0x0C: length bits 47:32, from data bits 15:0;
  - byte offset 0x14: pattern select, from data bits 2:0;
  - byte offset 0x20: timeout, from data bits 31:0.
- R4: A read of a write-only region (0x000–0x0FF, 0x200–0x2FF) or of an unmapped address returns zero, with the usual two-cycle valid strobe.
- R5: A write to byte address 0x010 raises `cmd_req` for exactly the following cycle. In the same cycle, `cmd_code` takes data bits 2:0 and `cmd_dev` takes data bits 9:8. Both fields hold their values until the next command write. The codes are:
  - 000: identify;
  - 001: shutdown;
  - 010: write;
  - 011: read;
  - 100: health log;
  - 110: flush;
  - 101 and 111: reserved. These are forwarded unchanged.
- R6: A read of 0x100 returns the status word, with these bits and all other bits zero:
  - bit 0: busy;
  - bit 1: error;
  - bit 2: verify-fail;
  - bits 19:16: device-detect;
  - bits 25:24: error device.

  A read of 0x10C returns the 32-bit error code. Other status offsets read zero.
- R7: A write to 0x200 + 4·n (n = 0..15) sets dword n of the command entry, which drives `cmd_entry[32n+31:32n]`.
- R8: A read of 0x300 + 4·n (n = 0..3) returns `cpl_dw[32n+31:32n]`. Writes to this region change nothing.
- R9: A read in 0x2000–0x3FFF returns dword `addr[3:2]` of identify RAM word `addr[12:4]`. Writes to this region leave the RAM unchanged.
- R10: A write in 0x4000–0x5FFF asserts `cram_we` in the same cycle, with `cram_addr = addr[12:4]` and the data replicated on all four dwords. Dword `addr[3:2]` is enabled, and enable bit k drives byte enables 4k+3:4k. Reads return dword `addr[3:2]` of the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address, shared by read and write |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Write data |
| reg_wr_be | input | 4 | Byte enables (ignored) |
| reg_rd_req | input | 1 | Read request strobe |
| reg_rd_data | output | 32 | Read data |
| reg_rd_valid | output | 1 | Read data valid, two cycles after request |
| prm_start_addr | output | 32+HI_W | Start address in sectors |
| prm_xfer_len | output | 32+HI_W | Transfer length in sectors |
| prm_patt_sel | output | 3 | Test pattern select |
| prm_timeout | output | 32 | Engine timeout value |
| cmd_req | output | 1 | One-cycle command launch |
| cmd_code | output | 3 | Command code |
| cmd_dev | output | DEV_SEL_W | Target device number |
| cmd_entry | output | ENTRY_N*32 | Command entry dwords |
| st_busy | input | 1 | Engine busy |
| st_error | input | 1 | Engine error |
| st_verify_fail | input | 1 | Data compare failure |
| st_dev_found | input | 2**DEV_SEL_W | Per-device detect flags |
| st_err_dev | input | DEV_SEL_W | Device that raised the error |
| st_err_code | input | 32 | Error type word |
| cpl_dw | input | COMP_N*32 | Completion dwords |
| iram_addr | output | RAM_AW | Identify RAM word address |
| iram_rd_data | input | RAM_DATA_W | Identify RAM read data (1-cycle) |
| cram_addr | output | RAM_AW | Command RAM word address |
| cram_we | output | 1 | Command RAM write enable |
| cram_wr_data | output | RAM_DATA_W | Command RAM write data |
| cram_be | output | RAM_DATA_W/8 | Command RAM byte enables |
| cram_rd_data | input | RAM_DATA_W | Command RAM read data (1-cycle) |

## Verification
The bench builds the block with its defaults:
- a 16-bit address;
- 16-bit high halves;
- two device-select bits, so four detect flags;
- a 16-dword entry and four completion dwords;
- 128-bit RAMs, which gives 512-word windows.

With these values, the extreme addresses 0x3FFC and 0x5FFC reach the last RAM word and dword 3. The error-device field reaches its top bits 25:24, and every completion and entry slice is addressable. Behavioural RAM models with one-cycle reads stand in for the two windows, so read-back covers the full two-stage path.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
   typedef enum logic [2:0] {
      AREA_NONE  = 3'd0,
      AREA_PARAM = 3'd1,
      AREA_STAT  = 3'd2,
      AREA_ENTRY = 3'd3,
      AREA_COMP  = 3'd4,
      AREA_IRAM  = 3'd5,
      AREA_CRAM  = 3'd6
   } area_e;

   localparam int REG_W      = 32;
   localparam int IDX_W      = 6;   // dword index inside a 256-byte region
   localparam int WINDOW_LOG = 13;  // 8 KB RAM windows
endpackage

// File: rtl/tcr_area_dec.sv
module tcr_area_dec #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output tcr_pkg::area_e    area
);
   import tcr_pkg::*;

   logic upper_zero;
   assign upper_zero = (addr[ADDR_W-1:15] == '0);

   logic unused_lo;
   assign unused_lo = ^addr[7:0];

   always_comb begin
      area = AREA_NONE;
      if (upper_zero) begin
         unique case (addr[14:13])
            2'b00: begin
               if (addr[12:10] == 3'b000) begin
                  unique case (addr[9:8])
                     2'b00: area = AREA_PARAM;
                     2'b01: area = AREA_STAT;
                     2'b10: area = AREA_ENTRY;
                     2'b11: area = AREA_COMP;
                  endcase
               end
            end
            2'b01:   area = AREA_IRAM;
            2'b10:   area = AREA_CRAM;
            default: area = AREA_NONE;
         endcase
      end
   end
endmodule

// File: rtl/tcr_param_bank.sv
module tcr_param_bank #(
   parameter int HI_W      = 16,
   parameter int DEV_SEL_W = 2,
   parameter int ENTRY_N   = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      prm_we,
   input  logic                      ent_we,
   input  logic [tcr_pkg::IDX_W-1:0] idx,
   input  logic [31:0]               wdata,
   output logic [32+HI_W-1:0]        start_addr,
   output logic [32+HI_W-1:0]        xfer_len,
   output logic [2:0]                patt_sel,
   output logic [31:0]               timeout,
   output logic                      cmd_req,
   output logic [2:0]                cmd_code,
   output logic [DEV_SEL_W-1:0]      cmd_dev,
   output logic [ENTRY_N*32-1:0]     entry
);
   import tcr_pkg::*;

   localparam logic [IDX_W-1:0] IX_SA_LO = 6'd0;
   localparam logic [IDX_W-1:0] IX_SA_HI = 6'd1;
   localparam logic [IDX_W-1:0] IX_LN_LO = 6'd2;
   localparam logic [IDX_W-1:0] IX_LN_HI = 6'd3;
   localparam logic [IDX_W-1:0] IX_CMD   = 6'd4;
   localparam logic [IDX_W-1:0] IX_PATT  = 6'd5;
   localparam logic [IDX_W-1:0] IX_TMO   = 6'd8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_addr <= '0;
         xfer_len   <= '0;
         patt_sel   <= '0;
         timeout    <= '0;
         cmd_req    <= 1'b0;
         cmd_code   <= '0;
         cmd_dev    <= '0;
      end else begin
         cmd_req <= 1'b0;
         if (prm_we) begin
            unique case (idx)
               IX_SA_LO: start_addr[31:0]       <= wdata;
               IX_SA_HI: start_addr[32 +: HI_W] <= wdata[HI_W-1:0];
               IX_LN_LO: xfer_len[31:0]         <= wdata;
               IX_LN_HI: xfer_len[32 +: HI_W]   <= wdata[HI_W-1:0];
               IX_CMD: begin
                  cmd_req  <= 1'b1;
                  cmd_code <= wdata[2:0];
                  cmd_dev  <= wdata[8 +: DEV_SEL_W];
               end
               IX_PATT:  patt_sel <= wdata[2:0];
               IX_TMO:   timeout  <= wdata;
               default: ;
            endcase
         end
      end
   end

   for (genvar n = 0; n < ENTRY_N; n++) begin : g_ent
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (ent_we && idx == IDX_W'(n))
            q <= wdata;
      end
      assign entry[n*32 +: 32] = q;
   end

   // R5
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_req |-> ($stable(cmd_code) && $stable(cmd_dev)));
   // R5
   cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> $past(prm_we));
endmodule

// File: rtl/tcr_rd_mux.sv
module tcr_rd_mux #(
   parameter int DEV_SEL_W  = 2,
   parameter int COMP_N     = 4,
   parameter int RAM_DATA_W = 128,
   parameter int SEL_W      = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd_req,
   input  tcr_pkg::area_e            area,
   input  logic [tcr_pkg::IDX_W-1:0] idx,
   input  logic [SEL_W-1:0]          sel,
   input  logic [31:0]               stat_word,
   input  logic [31:0]               err_code,
   input  logic [COMP_N*32-1:0]      comp,
   input  logic [RAM_DATA_W-1:0]     iram_d,
   input  logic [RAM_DATA_W-1:0]     cram_d,
   output logic [31:0]               rd_data,
   output logic                      rd_valid
);
   import tcr_pkg::*;

   // first level: word within region
   logic [31:0] loc;
   always_comb begin
      loc = '0;
      if (area == AREA_STAT) begin
         if (idx == 6'd0)      loc = stat_word;
         else if (idx == 6'd3) loc = err_code;
      end else if (area == AREA_COMP) begin
         for (int n = 0; n < COMP_N; n++)
            if (idx == IDX_W'(n)) loc = comp[n*32 +: 32];
      end
   end

   logic             v1;
   area_e            area1;
   logic [SEL_W-1:0] sel1;
   logic [31:0]      loc1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         area1 <= AREA_NONE;
         sel1  <= '0;
         loc1  <= '0;
      end else begin
         v1 <= rd_req;
         if (rd_req) begin
            area1 <= area;
            sel1  <= sel;
            loc1  <= loc;
         end
      end
   end

   // second level: region select
   logic [31:0] pick;
   always_comb begin
      unique case (area1)
         AREA_STAT, AREA_COMP: pick = loc1;
         AREA_IRAM:            pick = iram_d[sel1*32 +: 32];
         AREA_CRAM:            pick = cram_d[sel1*32 +: 32];
         default:              pick = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= v1;
         rd_data  <= v1 ? pick : '0;
      end
   end

   // R2
   rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> ##1 rd_valid);
   // R2
   rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req, 2));
endmodule

// File: rtl/tcr_be_expand.sv
module tcr_be_expand #(
   parameter int DWORDS = 4
) (
   input  logic [DWORDS-1:0]   dw_en,
   output logic [DWORDS*4-1:0] be
);
   for (genvar k = 0; k < DWORDS; k++) begin : g_dw
      assign be[k*4 +: 4] = {4{dw_en[k]}};
   end
endmodule

// File: rtl/tcr_regfile.sv
module tcr_regfile #(
   parameter int ADDR_W     = 16,
   parameter int HI_W       = 16,
   parameter int DEV_SEL_W  = 2,
   parameter int ENTRY_N    = 16,
   parameter int COMP_N     = 4,
   parameter int RAM_DATA_W = 128,
   localparam int DEV_N     = 1 << DEV_SEL_W,
   localparam int BYTE_SH   = $clog2(RAM_DATA_W / 8),
   localparam int RAM_AW    = tcr_pkg::WINDOW_LOG - BYTE_SH,
   localparam int DWORDS    = RAM_DATA_W / 32,
   localparam int SEL_W     = $clog2(DWORDS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic                      reg_wr_en,
   input  logic [31:0]               reg_wr_data,
   input  logic [3:0]                reg_wr_be,
   input  logic                      reg_rd_req,
   output logic [31:0]               reg_rd_data,
   output logic                      reg_rd_valid,
   output logic [32+HI_W-1:0]        prm_start_addr,
   output logic [32+HI_W-1:0]        prm_xfer_len,
   output logic [2:0]                prm_patt_sel,
   output logic [31:0]               prm_timeout,
   output logic                      cmd_req,
   output logic [2:0]                cmd_code,
   output logic [DEV_SEL_W-1:0]      cmd_dev,
   output logic [ENTRY_N*32-1:0]     cmd_entry,
   input  logic                      st_busy,
   input  logic                      st_error,
   input  logic                      st_verify_fail,
   input  logic [DEV_N-1:0]          st_dev_found,
   input  logic [DEV_SEL_W-1:0]      st_err_dev,
   input  logic [31:0]               st_err_code,
   input  logic [COMP_N*32-1:0]      cpl_dw,
   output logic [RAM_AW-1:0]         iram_addr,
   input  logic [RAM_DATA_W-1:0]     iram_rd_data,
   output logic [RAM_AW-1:0]         cram_addr,
   output logic                      cram_we,
   output logic [RAM_DATA_W-1:0]     cram_wr_data,
   output logic [RAM_DATA_W/8-1:0]   cram_be,
   input  logic [RAM_DATA_W-1:0]     cram_rd_data
);
   import tcr_pkg::*;

   initial begin
      assert (ADDR_W >= 16) else $fatal(1, "ADDR_W must cover 0x5FFF");
      assert (HI_W >= 1 && HI_W <= 32) else $fatal(1, "HI_W out of range");
      assert (DEV_SEL_W >= 1 && DEV_SEL_W <= 3) else $fatal(1, "DEV_SEL_W out of range");
      assert (ENTRY_N >= 1 && ENTRY_N <= 64) else $fatal(1, "ENTRY_N exceeds region");
      assert (COMP_N >= 1 && COMP_N <= 64) else $fatal(1, "COMP_N exceeds region");
      assert (RAM_DATA_W >= 64 && (RAM_DATA_W & (RAM_DATA_W - 1)) == 0)
         else $fatal(1, "RAM_DATA_W must be a power of two >= 64");
   end

   logic unused_bits;
   assign unused_bits = ^{reg_wr_be, reg_addr[1:0]};

   area_e area;
   tcr_area_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(reg_addr), .area(area));

   logic [IDX_W-1:0] idx;
   logic [SEL_W-1:0] sel;
   assign idx = reg_addr[7:2];
   assign sel = reg_addr[BYTE_SH-1:2];

   tcr_param_bank #(.HI_W(HI_W), .DEV_SEL_W(DEV_SEL_W), .ENTRY_N(ENTRY_N)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .prm_we     (reg_wr_en && area == AREA_PARAM),
      .ent_we     (reg_wr_en && area == AREA_ENTRY),
      .idx        (idx),
      .wdata      (reg_wr_data),
      .start_addr (prm_start_addr),
      .xfer_len   (prm_xfer_len),
      .patt_sel   (prm_patt_sel),
      .timeout    (prm_timeout),
      .cmd_req    (cmd_req),
      .cmd_code   (cmd_code),
      .cmd_dev    (cmd_dev),
      .entry      (cmd_entry)
   );

   // RAM windows
   logic [DWORDS-1:0] dw_en;
   assign iram_addr    = reg_addr[BYTE_SH +: RAM_AW];
   assign cram_addr    = reg_addr[BYTE_SH +: RAM_AW];
   assign cram_we      = reg_wr_en && area == AREA_CRAM;
   assign cram_wr_data = {DWORDS{reg_wr_data}};
   assign dw_en        = cram_we ? (DWORDS'(1) << sel) : '0;

   tcr_be_expand #(.DWORDS(DWORDS)) u_be (.dw_en(dw_en), .be(cram_be));

   // status word
   logic [31:0] stat_word;
   always_comb begin
      stat_word                  = '0;
      stat_word[0]               = st_busy;
      stat_word[1]               = st_error;
      stat_word[2]               = st_verify_fail;
      stat_word[16 +: DEV_N]     = st_dev_found;
      stat_word[24 +: DEV_SEL_W] = st_err_dev;
   end

   tcr_rd_mux #(.DEV_SEL_W(DEV_SEL_W), .COMP_N(COMP_N),
                .RAM_DATA_W(RAM_DATA_W), .SEL_W(SEL_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (reg_rd_req),
      .area      (area),
      .idx       (idx),
      .sel       (sel),
      .stat_word (stat_word),
      .err_code  (st_err_code),
      .comp      (cpl_dw),
      .iram_d    (iram_rd_data),
      .cram_d    (cram_rd_data),
      .rd_data   (reg_rd_data),
      .rd_valid  (reg_rd_valid)
   );

   // R10
   cram_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cram_we |-> ($countones(cram_be) == 4));
   // R10
   cram_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr_en |-> (cram_be == '0 && !cram_we));
   // R5
   cmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> ($past(reg_wr_en) && $past(reg_addr) == ADDR_W'(16'h0010)));
   // R9
   iram_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr[ADDR_W-1:13] == (ADDR_W-13)'(1)) |-> !cram_we);
endmodule

// File: tb/tcr_regfile_test.sv
module tcr_regfile_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [15:0]  reg_addr = '0;
   logic         reg_wr_en = 1'b0;
   logic [31:0]  reg_wr_data = '0;
   logic [3:0]   reg_wr_be = '0;
   logic         reg_rd_req = 1'b0;
   logic [31:0]  reg_rd_data;
   logic         reg_rd_valid;
   logic [47:0]  prm_start_addr, prm_xfer_len;
   logic [2:0]   prm_patt_sel;
   logic [31:0]  prm_timeout;
   logic         cmd_req;
   logic [2:0]   cmd_code;
   logic [1:0]   cmd_dev;
   logic [511:0] cmd_entry;
   logic         st_busy = 0, st_error = 0, st_verify_fail = 0;
   logic [3:0]   st_dev_found = '0;
   logic [1:0]   st_err_dev = '0;
   logic [31:0]  st_err_code = '0;
   logic [127:0] cpl_dw = '0;
   logic [8:0]   iram_addr, cram_addr;
   logic [127:0] iram_rd_data, cram_rd_data, cram_wr_data;
   logic         cram_we;
   logic [15:0]  cram_be;

   tcr_regfile uut (.*);

   // RAM models
   logic [127:0] iram [512];
   logic [127:0] cram [512];
   function automatic logic [31:0] ival(int w, int k); return 32'h1D00_0000 | (w << 4) | k; endfunction
   function automatic logic [31:0] cval(int w, int k); return 32'hC000_0000 | (w << 4) | k; endfunction
   initial begin
      for (int w = 0; w < 512; w++)
         for (int k = 0; k < 4; k++) begin
            iram[w][k*32 +: 32] = ival(w, k);
            cram[w][k*32 +: 32] = cval(w, k);
         end
   end
   always @(posedge clk) begin
      iram_rd_data <= iram[iram_addr];
      cram_rd_data <= cram[cram_addr];
      if (cram_we)
         for (int b = 0; b < 16; b++)
            if (cram_be[b]) cram[cram_addr][b*8 +: 8] <= cram_wr_data[b*8 +: 8];
   end

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   task automatic check(input string rq, input logic [511:0] act, input logic [511:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_addr = a; reg_wr_data = d; reg_wr_be = be; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd_req = 1'b1;
      @(negedge clk);
      reg_rd_req = 1'b0;
      check("R2 valid not after one cycle", reg_rd_valid, 0);
      @(negedge clk);
      check("R2 valid after two cycles", reg_rd_valid, 1);
      d = reg_rd_data;
   endtask

   task automatic t_reset();
      check("R1 start addr", prm_start_addr, 0);
      check("R1 length", prm_xfer_len, 0);
      check("R1 pattern/timeout", {prm_patt_sel, prm_timeout}, 0);
      check("R1 cmd fields", {cmd_req, cmd_code, cmd_dev}, 0);
      check("R1 entry", cmd_entry, 0);
      check("R1 rd_valid", reg_rd_valid, 0);
   endtask

   task automatic t_params();
      logic [31:0] d;
      wr(16'h0000, 32'hA1B2_C3D4, 4'b0000);
      wr(16'h0004, 32'hFFFF_1234, 4'b0001);
      wr(16'h0008, 32'h0000_0800, 4'b1000);
      wr(16'h000C, 32'h5555_0007, 4'b0000);
      wr(16'h0014, 32'hFFFF_FFFC, 4'b0000);
      wr(16'h0020, 32'h0BAD_F00D, 4'b0010);
      check("R3 start addr", prm_start_addr, 48'h1234_A1B2_C3D4);
      check("R3 length", prm_xfer_len, 48'h0007_0000_0800);
      check("R3 pattern", prm_patt_sel, 3'b100);
      check("R3 timeout", prm_timeout, 32'h0BAD_F00D);
      rd(16'h0008, d); check("R4 param area reads zero", d, 0);
      rd(16'h7000, d); check("R4 unmapped reads zero", d, 0);
      rd(16'h0800, d); check("R4 unmapped low reads zero", d, 0);
   endtask

   task automatic t_cmd();
      wr(16'h0010, 32'hFFFF_FE02, 4'b0000);
      check("R5 cmd pulse", cmd_req, 1);
      check("R5 code/dev", {cmd_code, cmd_dev}, {3'b010, 2'b10});
      @(negedge clk);
      check("R5 pulse one cycle", cmd_req, 0);
      wr(16'h0014, 32'h0000_0001, 4'b1111);
      check("R5 fields held", {cmd_req, cmd_code, cmd_dev}, {1'b0, 3'b010, 2'b10});
      wr(16'h0010, 32'h0000_0105, 4'b1111);
      check("R5 reserved code forwarded", {cmd_req, cmd_code, cmd_dev}, {1'b1, 3'b101, 2'b01});
      wr(16'h0010, 32'h0000_0306, 4'b1111);
      check("R5 flush", {cmd_req, cmd_code, cmd_dev}, {1'b1, 3'b110, 2'b11});
   endtask

   task automatic t_status();
      logic [31:0] d;
      st_busy = 1; st_error = 0; st_verify_fail = 1;
      st_dev_found = 4'b1010; st_err_dev = 2'd2; st_err_code = 32'hDEAD_0042;
      rd(16'h0100, d); check("R6 status word", d, 32'h020A_0005);
      st_busy = 0; st_error = 1; st_verify_fail = 0; st_dev_found = 4'b0001; st_err_dev = 2'd3;
      rd(16'h0100, d); check("R6 status word 2", d, 32'h0301_0002);
      rd(16'h010C, d); check("R6 error code", d, 32'hDEAD_0042);
      rd(16'h0104, d); check("R6 other offset zero", d, 0);
   endtask

   task automatic t_entry();
      logic [511:0] exp = '0;
      logic [31:0] d;
      for (int n = 0; n < 16; n++) begin
         wr(16'h0200 + 16'(n * 4), 32'hE000_0000 + 32'(n * 32'h1111), 4'b0000);
         exp[n*32 +: 32] = 32'hE000_0000 + 32'(n * 32'h1111);
      end
      check("R7 entry dwords", cmd_entry, exp);
      rd(16'h0204, d); check("R4 entry area reads zero", d, 0);
   endtask

   task automatic t_comp();
      logic [31:0] d;
      cpl_dw = {32'h4444_0003, 32'h3333_0002, 32'h2222_0001, 32'h1111_0000};
      rd(16'h0300, d); check("R8 completion dw0", d, 32'h1111_0000);
      rd(16'h030C, d); check("R8 completion dw3", d, 32'h4444_0003);
      wr(16'h0304, 32'h0, 4'b1111);
      rd(16'h0304, d); check("R8 write ignored dw1", d, 32'h2222_0001);
   endtask

   task automatic t_iram();
      logic [31:0] d;
      rd(16'h2000, d); check("R9 iram first", d, ival(0, 0));
      rd(16'h2A18, d); check("R9 iram mid", d, ival(9'hA1, 2));
      rd(16'h3FFC, d); check("R9 iram last", d, ival(9'h1FF, 3));
      wr(16'h2004, 32'h0, 4'b1111);
      rd(16'h2004, d); check("R9 iram write ignored", d, ival(0, 1));
   endtask

   task automatic t_cram();
      logic [31:0] d;
      @(negedge clk);
      reg_addr = 16'h4018; reg_wr_data = 32'h1234_5678; reg_wr_be = 4'b0000; reg_wr_en = 1'b1;
      #1;
      check("R10 write enable", cram_we, 1);
      check("R10 byte enables dword2", cram_be, 16'h0F00);
      check("R10 word address", cram_addr, 9'd1);
      check("R10 replicated data", cram_wr_data, {4{32'h1234_5678}});
      @(negedge clk);
      reg_wr_en = 1'b0;
      rd(16'h4018, d); check("R10 readback", d, 32'h1234_5678);
      rd(16'h4014, d); check("R10 neighbour dword1 kept", d, cval(1, 1));
      rd(16'h401C, d); check("R10 neighbour dword3 kept", d, cval(1, 3));
      wr(16'h5FFC, 32'hCAFE_BABE, 4'b0001);
      rd(16'h5FFC, d); check("R10 last dword", d, 32'hCAFE_BABE);
      rd(16'h5FF0, d); check("R10 last word dword0 kept", d, cval(9'h1FF, 0));
   endtask

   task automatic t_latency();
      logic [31:0] a, b;
      st_err_code = 32'h0000_BEEF;
      @(negedge clk);
      reg_addr = 16'h010C; reg_rd_req = 1'b1;
      @(negedge clk);
      reg_addr = 16'h0300;
      check("R2 b2b first not early", reg_rd_valid, 0);
      @(negedge clk);
      reg_rd_req = 1'b0;
      check("R2 b2b valid 1", reg_rd_valid, 1);
      a = reg_rd_data;
      @(negedge clk);
      check("R2 b2b valid 2", reg_rd_valid, 1);
      b = reg_rd_data;
      @(negedge clk);
      check("R2 single strobe per request", reg_rd_valid, 0);
      check("R2 b2b data", {a, b}, {32'h0000_BEEF, 32'h1111_0000});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_params();
      t_cmd();
      t_status();
      t_entry();
      t_comp();
      t_iram();
      t_cram();
      t_latency();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule